// File: doc/BRIEF.md
# Port Pin Override Signal Generator

This block sits between a microcontroller's on-chip peripherals and the eight pin controllers of one 8-bit general-purpose port. Each pin controller takes, besides its own direction, output latch and pull-up settings, four override pairs: pull-up, direction, driven value and digital-input enable. Each pair has an enable that takes over from the controller's normal setting and a value that is used in its place. This block works out all of those pairs from the state of the peripherals that share the port. It is purely combinational.

The port is shared by a serial peripheral interface (clock, master-out, master-in and select lines), three timer compare outputs, pin-change wake-up inputs, the two crystal oscillator pins and a divided system clock output. Pin assignment: bit 0 divided clock output, bit 1 compare output 0, bit 2 serial select and compare output 1, bit 3 master-out data and compare output 2, bit 4 master-in data, bit 5 serial clock, bits 6 and 7 crystal pins. A pin controller resolves its direction as `dir_ovr_en ? dir_ovr_val : own direction bit`, and its driven value likewise from `drv_ovr_*` and its latch bit.

Top module: `port_override_gen`

## Requirements
- R1: With `spi_en`=1 and `spi_master`=0 (slave role), pins 5, 3 and 2 have direction override enabled with value 0 (input); in any other role these three pins have no direction override.
- R2: With `spi_en`=1 and `spi_master`=1, pin 4 has direction override enabled with value 0; otherwise pin 4 has no direction override.
- R3: Every pin forced to input by R1 or R2 has pull-up override enabled with value `latch[i] & ~pull_dis`; pins 2 to 5 have no pull-up override when not forced.
- R4: In master role pin 5 has its driven-value override enabled at `sck_out`; in slave role pin 4 has it enabled at `miso_out`; neither pin has a value override otherwise.
- R5: Pin 3 has its value override enabled when the interface is an enabled master or `cmp_en[2]`=1; the value is `mosi_out` in master role and `cmp_lvl[2]` otherwise.
- R6: Compare output k (bit k of `cmp_en`/`cmp_lvl`, k = 0, 1) drives pin k+1 through a value override while enabled; compare outputs never override direction, so pin 1 never has a direction override.
- R7: For every pin i, the input-enable override enable is `chg_mask[i] & chg_grp_en` and the override value is 1.
- R8: `clk_src` encodes 2'b00 crystal, 2'b01 internal RC, 2'b10 external clock, 2'b11 treated as crystal. When internal RC is selected with `async_tmr`=1, or external clock is selected, pins 6 and 7 have pull-up and direction overrides enabled with value 0; otherwise they have none. Pins 6 and 7 never have a value override.
- R9: When `clkdiv_en`=1 or `sys_rst`=1, pin 0 has direction override enabled at 1 and value override enabled at `clkdiv`; otherwise pin 0 has no direction, pull-up or value override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| spi_en | input | 1 | Serial interface enabled |
| spi_master | input | 1 | Serial interface role: 1 master, 0 slave |
| sck_out | input | 1 | Serial clock generated in master role |
| mosi_out | input | 1 | Serial data driven in master role |
| miso_out | input | 1 | Serial data driven in slave role |
| cmp_en | input | 3 | Compare output enables, bit k for pin k+1 |
| cmp_lvl | input | 3 | Compare output levels, bit k for pin k+1 |
| chg_mask | input | 8 | Per-pin change-detect mask |
| chg_grp_en | input | 1 | Change-detect group enable |
| clk_src | input | 2 | Chip clock source code |
| async_tmr | input | 1 | Asynchronous timer clocking enabled |
| latch | input | 8 | Port output latch bits |
| pull_dis | input | 1 | Global pull-up disable |
| clkdiv_en | input | 1 | Divided clock output enable |
| clkdiv | input | 1 | Divided system clock |
| sys_rst | input | 1 | Chip reset active |
| pu_ovr_en | output | 8 | Pull-up override enables |
| pu_ovr_val | output | 8 | Pull-up override values |
| dir_ovr_en | output | 8 | Direction override enables |
| dir_ovr_val | output | 8 | Direction override values (1 output) |
| drv_ovr_en | output | 8 | Driven-value override enables |
| drv_ovr_val | output | 8 | Driven-value override values |
| din_ovr_en | output | 8 | Digital-input enable override enables |
| din_ovr_val | output | 8 | Digital-input enable override values |

## Verification
The block holds no state, so a wrong decode shows at the override outputs in the same evaluation as the input change that exposes it, and the bench resolves each pin's direction and driven value the way a pin controller would. A role decode error appears as a serial pin that follows its own direction bit when it should be an input, or the reverse; a mis-ordered priority on the shared master-out pin shows as the compare level driven while the interface is master. Sweeping every role and compare-enable combination under two direction settings and two data polarities leaves no decode term that could stay stuck without changing a resolved pin.

// File: rtl/pin_ovr_pkg.sv
package pin_ovr_pkg;

  localparam int NPINS = 8;
  localparam int NCMP  = 3;

  // Pin assignment: the neighbouring pin controllers are wired by index.
  localparam int PIN_CLKDIV = 0;
  localparam int PIN_CMP0   = 1;
  localparam int PIN_SEL    = 2;
  localparam int PIN_MOSI   = 3;
  localparam int PIN_MISO   = 4;
  localparam int PIN_SCK    = 5;
  localparam int PIN_XT1    = 6;
  localparam int PIN_XT2    = 7;

  typedef enum logic [1:0] {
    CLK_CRYSTAL = 2'b00,
    CLK_RC      = 2'b01,
    CLK_EXT     = 2'b10,
    CLK_RSVD    = 2'b11
  } clk_src_e;

  typedef struct packed {
    logic pu_en;
    logic pu_val;
    logic dir_en;
    logic dir_val;
    logic drv_en;
    logic drv_val;
    logic din_en;
    logic din_val;
  } pin_ovr_t;

  // Pull-up kept under latch control on a forced input.
  function automatic logic keep_pullup(input logic latch_bit, input logic pull_off);
    return latch_bit & ~pull_off;
  endfunction

  // Crystal pins are taken by the clock system.
  function automatic logic xtal_taken(input logic [1:0] src, input logic async_on);
    return ((src == CLK_RC) && async_on) || (src == CLK_EXT);
  endfunction

  // Value shared by the master-out pin: serial data wins over compare level.
  function automatic logic shared_mosi(input logic master_on, input logic spi_data,
                                       input logic cmp_level);
    return master_on ? spi_data : cmp_level;
  endfunction

endpackage

// File: rtl/ovr_serial_cmp.sv
module ovr_serial_cmp
  import pin_ovr_pkg::*;
(
  input  logic                   spi_en,
  input  logic                   spi_master,
  input  logic                   sck_out,
  input  logic                   mosi_out,
  input  logic                   miso_out,
  input  logic [NCMP-1:0]        cmp_en,
  input  logic [NCMP-1:0]        cmp_lvl,
  input  logic [NPINS-1:0]       latch,
  input  logic                   pull_dis,
  output pin_ovr_t [NPINS-1:0]   ovr,
  output logic                   slave_act,
  output logic                   master_act
);

  localparam logic [NPINS-1:0] SLAVE_IN  = NPINS'((1 << PIN_SCK) | (1 << PIN_MOSI) | (1 << PIN_SEL));
  localparam logic [NPINS-1:0] MASTER_IN = NPINS'(1 << PIN_MISO);

  logic [NPINS-1:0] forced_in;

  assign slave_act  = spi_en & ~spi_master;
  assign master_act = spi_en & spi_master;
  assign forced_in  = ({NPINS{slave_act}} & SLAVE_IN) | ({NPINS{master_act}} & MASTER_IN);

  always_comb begin
    ovr = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (forced_in[i]) begin
        ovr[i].pu_en   = 1'b1;
        ovr[i].pu_val  = keep_pullup(latch[i], pull_dis);
        ovr[i].dir_en  = 1'b1;
        ovr[i].dir_val = 1'b0;
      end
    end
    // serial clock out in master role
    ovr[PIN_SCK].drv_en   = master_act;
    ovr[PIN_SCK].drv_val  = sck_out;
    // slave data out
    ovr[PIN_MISO].drv_en  = slave_act;
    ovr[PIN_MISO].drv_val = miso_out;
    // shared master-out / compare 2
    ovr[PIN_MOSI].drv_en  = master_act | cmp_en[2];
    ovr[PIN_MOSI].drv_val = shared_mosi(master_act, mosi_out, cmp_lvl[2]);
    // compare 1 on select pin, compare 0 on its own pin
    ovr[PIN_SEL].drv_en   = cmp_en[1];
    ovr[PIN_SEL].drv_val  = cmp_lvl[1];
    ovr[PIN_CMP0].drv_en  = cmp_en[0];
    ovr[PIN_CMP0].drv_val = cmp_lvl[0];
  end

endmodule

// File: rtl/ovr_clock_pins.sv
module ovr_clock_pins
  import pin_ovr_pkg::*;
(
  input  logic                 [1:0] clk_src,
  input  logic                       async_tmr,
  input  logic                       clkdiv_en,
  input  logic                       clkdiv,
  input  logic                       sys_rst,
  output pin_ovr_t [NPINS-1:0]       ovr,
  output logic                       xtal_force,
  output logic                       clkdiv_act
);

  assign xtal_force = xtal_taken(clk_src, async_tmr);
  assign clkdiv_act = clkdiv_en | sys_rst;

  always_comb begin
    ovr = '0;
    ovr[PIN_XT1].pu_en  = xtal_force;
    ovr[PIN_XT1].dir_en = xtal_force;
    ovr[PIN_XT2].pu_en  = xtal_force;
    ovr[PIN_XT2].dir_en = xtal_force;
    ovr[PIN_CLKDIV].dir_en  = clkdiv_act;
    ovr[PIN_CLKDIV].dir_val = clkdiv_act;
    ovr[PIN_CLKDIV].drv_en  = clkdiv_act;
    ovr[PIN_CLKDIV].drv_val = clkdiv_act & clkdiv;
  end

endmodule

// File: rtl/ovr_wake.sv
module ovr_wake
  import pin_ovr_pkg::*;
(
  input  logic [NPINS-1:0]       chg_mask,
  input  logic                   chg_grp_en,
  output pin_ovr_t [NPINS-1:0]   ovr
);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign ovr[g] = '{din_en: chg_mask[g] & chg_grp_en, din_val: 1'b1, default: 1'b0};
  end

endmodule

// File: rtl/port_override_gen.sv
module port_override_gen
  import pin_ovr_pkg::*;
(
  input  logic             spi_en,
  input  logic             spi_master,
  input  logic             sck_out,
  input  logic             mosi_out,
  input  logic             miso_out,
  input  logic [2:0]       cmp_en,
  input  logic [2:0]       cmp_lvl,
  input  logic [7:0]       chg_mask,
  input  logic             chg_grp_en,
  input  logic [1:0]       clk_src,
  input  logic             async_tmr,
  input  logic [7:0]       latch,
  input  logic             pull_dis,
  input  logic             clkdiv_en,
  input  logic             clkdiv,
  input  logic             sys_rst,
  output logic [7:0]       pu_ovr_en,
  output logic [7:0]       pu_ovr_val,
  output logic [7:0]       dir_ovr_en,
  output logic [7:0]       dir_ovr_val,
  output logic [7:0]       drv_ovr_en,
  output logic [7:0]       drv_ovr_val,
  output logic [7:0]       din_ovr_en,
  output logic [7:0]       din_ovr_val
);

  pin_ovr_t [NPINS-1:0] ovr_sc, ovr_ck, ovr_wk, ovr_all;
  logic slave_act, master_act, xtal_force, clkdiv_act;

  ovr_serial_cmp u_sc (
    .spi_en(spi_en), .spi_master(spi_master), .sck_out(sck_out),
    .mosi_out(mosi_out), .miso_out(miso_out), .cmp_en(cmp_en),
    .cmp_lvl(cmp_lvl), .latch(latch), .pull_dis(pull_dis),
    .ovr(ovr_sc), .slave_act(slave_act), .master_act(master_act)
  );

  ovr_clock_pins u_ck (
    .clk_src(clk_src), .async_tmr(async_tmr), .clkdiv_en(clkdiv_en),
    .clkdiv(clkdiv), .sys_rst(sys_rst), .ovr(ovr_ck),
    .xtal_force(xtal_force), .clkdiv_act(clkdiv_act)
  );

  ovr_wake u_wk (
    .chg_mask(chg_mask), .chg_grp_en(chg_grp_en), .ovr(ovr_wk)
  );

  // Each sub-block leaves the fields it does not own at zero.
  assign ovr_all = ovr_sc | ovr_ck | ovr_wk;

  for (genvar g = 0; g < NPINS; g++) begin : g_out
    assign pu_ovr_en[g]   = ovr_all[g].pu_en;
    assign pu_ovr_val[g]  = ovr_all[g].pu_val;
    assign dir_ovr_en[g]  = ovr_all[g].dir_en;
    assign dir_ovr_val[g] = ovr_all[g].dir_val;
    assign drv_ovr_en[g]  = ovr_all[g].drv_en;
    assign drv_ovr_val[g] = ovr_all[g].drv_val;
    assign din_ovr_en[g]  = ovr_all[g].din_en;
    assign din_ovr_val[g] = ovr_all[g].din_val;
  end

endmodule

// File: rtl/port_ovr_chk.sv
module port_ovr_chk (
  input logic       spi_en,
  input logic       spi_master,
  input logic       mosi_out,
  input logic [2:0] cmp_en,
  input logic [7:0] chg_mask,
  input logic       chg_grp_en,
  input logic [7:0] latch,
  input logic       pull_dis,
  input logic       clkdiv,
  input logic       slave_act,
  input logic       master_act,
  input logic       xtal_force,
  input logic       clkdiv_act,
  input logic [7:0] pu_ovr_en,
  input logic [7:0] pu_ovr_val,
  input logic [7:0] dir_ovr_en,
  input logic [7:0] dir_ovr_val,
  input logic [7:0] drv_ovr_en,
  input logic [7:0] drv_ovr_val,
  input logic [7:0] din_ovr_en,
  input logic [7:0] din_ovr_val
);

  logic known;
  assign known = !$isunknown({spi_en, spi_master, mosi_out, cmp_en, chg_mask, chg_grp_en,
                              latch, pull_dis, clkdiv, slave_act, master_act, xtal_force,
                              clkdiv_act, pu_ovr_en, pu_ovr_val, dir_ovr_en, dir_ovr_val,
                              drv_ovr_en, drv_ovr_val, din_ovr_en, din_ovr_val});

  always_comb begin
    if (known) begin
      assert_slave_inputs_R1: assert (!slave_act ||
        ((dir_ovr_en[5] & dir_ovr_en[3] & dir_ovr_en[2]) &&
         !(dir_ovr_val[5] | dir_ovr_val[3] | dir_ovr_val[2])))
        else $error("slave role left a serial pin undriven as input");
      assert_master_miso_R2: assert (!master_act || (dir_ovr_en[4] && !dir_ovr_val[4]))
        else $error("master role did not force master-in pin to input");
      assert_one_role_R2: assert ($countones({slave_act, master_act}) <= 1)
        else $error("both serial roles active");
      for (int i = 2; i <= 5; i++) begin
        assert_pullup_latch_R3: assert (!dir_ovr_en[i] ||
          (pu_ovr_en[i] && (pu_ovr_val[i] == (latch[i] && !pull_dis))))
          else $error("forced input pin lost latch pull-up control");
      end
      assert_mosi_priority_R5: assert (!master_act || (drv_ovr_en[3] && drv_ovr_val[3] == mosi_out))
        else $error("master-out pin not carrying serial data");
      assert_cmp_no_dir_R6: assert (!dir_ovr_en[1])
        else $error("compare pin direction overridden");
      assert_din_mask_R7: assert (((din_ovr_en & ~chg_mask) == 8'h00) &&
                                  (chg_grp_en || din_ovr_en == 8'h00) && (&din_ovr_val))
        else $error("input enable override outside mask");
      assert_xtal_off_R8: assert (!xtal_force ||
        (&pu_ovr_en[7:6] && &dir_ovr_en[7:6] && !(|pu_ovr_val[7:6]) && !(|dir_ovr_val[7:6])))
        else $error("crystal pins not released");
      assert_xtal_nodrv_R8: assert (drv_ovr_en[7:6] == 2'b00)
        else $error("crystal pins value overridden");
      assert_clkdiv_R9: assert (!clkdiv_act ||
        (dir_ovr_en[0] && dir_ovr_val[0] && drv_ovr_en[0] && drv_ovr_val[0] == clkdiv))
        else $error("divided clock not on pin 0");
    end
  end

endmodule

bind port_override_gen port_ovr_chk u_chk (
  .spi_en(spi_en), .spi_master(spi_master), .mosi_out(mosi_out), .cmp_en(cmp_en),
  .chg_mask(chg_mask), .chg_grp_en(chg_grp_en), .latch(latch), .pull_dis(pull_dis),
  .clkdiv(clkdiv), .slave_act(slave_act), .master_act(master_act),
  .xtal_force(xtal_force), .clkdiv_act(clkdiv_act),
  .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val), .dir_ovr_en(dir_ovr_en),
  .dir_ovr_val(dir_ovr_val), .drv_ovr_en(drv_ovr_en), .drv_ovr_val(drv_ovr_val),
  .din_ovr_en(din_ovr_en), .din_ovr_val(din_ovr_val)
);

// File: tb/port_override_gen_test.sv
module port_override_gen_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       spi_en, spi_master, sck_out, mosi_out, miso_out;
  logic [2:0] cmp_en, cmp_lvl;
  logic [7:0] chg_mask, latch;
  logic       chg_grp_en, async_tmr, pull_dis, clkdiv_en, clkdiv, sys_rst;
  logic [1:0] clk_src;
  logic [7:0] pu_ovr_en, pu_ovr_val, dir_ovr_en, dir_ovr_val;
  logic [7:0] drv_ovr_en, drv_ovr_val, din_ovr_en, din_ovr_val;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  port_override_gen uut (
    .spi_en(spi_en), .spi_master(spi_master), .sck_out(sck_out), .mosi_out(mosi_out),
    .miso_out(miso_out), .cmp_en(cmp_en), .cmp_lvl(cmp_lvl), .chg_mask(chg_mask),
    .chg_grp_en(chg_grp_en), .clk_src(clk_src), .async_tmr(async_tmr), .latch(latch),
    .pull_dis(pull_dis), .clkdiv_en(clkdiv_en), .clkdiv(clkdiv), .sys_rst(sys_rst),
    .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val), .dir_ovr_en(dir_ovr_en),
    .dir_ovr_val(dir_ovr_val), .drv_ovr_en(drv_ovr_en), .drv_ovr_val(drv_ovr_val),
    .din_ovr_en(din_ovr_en), .din_ovr_val(din_ovr_val)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    spi_en = 0; spi_master = 0; sck_out = 0; mosi_out = 0; miso_out = 0;
    cmp_en = 0; cmp_lvl = 0; chg_mask = 0; chg_grp_en = 0; clk_src = 2'b00;
    async_tmr = 0; latch = 0; pull_dis = 0; clkdiv_en = 0; clkdiv = 0; sys_rst = 0;
  endtask

  // Reset drives the divided clock on pin 0; nothing else is overridden.
  task automatic t_reset();
    idle(); sys_rst = 1; clkdiv = 1; #1;
    check("R9 reset pin0 dir en", dir_ovr_en, 8'h01);
    check("R9 reset pin0 dir val", dir_ovr_val, 8'h01);
    check("R9 reset pin0 drive", {drv_ovr_en, drv_ovr_val}, 16'h0101);
    check("R3 reset no pullup ovr", pu_ovr_en, 8'h00);
    check("R7 reset no din ovr", din_ovr_en, 8'h00);
  endtask

  task automatic t_sweep();
    logic [7:0] ddr, exp_dir, exp_val, res_dir, res_val;
    logic slv, mas;
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < 2; p++) begin
        for (int c = 0; c < 32; c++) begin
          idle();
          ddr = (d != 0) ? 8'hFF : 8'h00;
          spi_en = c[0]; spi_master = c[1]; cmp_en = c[4:2];
          if (p == 0) begin
            latch = 8'h00; sck_out = 1; mosi_out = 1; miso_out = 1; cmp_lvl = 3'b111;
          end else begin
            latch = 8'hFF; sck_out = 0; mosi_out = 0; miso_out = 0; cmp_lvl = 3'b000;
          end
          #1;
          slv = spi_en & ~spi_master;
          mas = spi_en & spi_master;
          exp_dir = ddr;
          if (slv) begin exp_dir[5] = 0; exp_dir[3] = 0; exp_dir[2] = 0; end
          if (mas) exp_dir[4] = 0;
          exp_val = latch;
          if (mas) exp_val[5] = sck_out;
          if (slv) exp_val[4] = miso_out;
          if (mas) exp_val[3] = mosi_out;
          else if (cmp_en[2]) exp_val[3] = cmp_lvl[2];
          if (cmp_en[1]) exp_val[2] = cmp_lvl[1];
          if (cmp_en[0]) exp_val[1] = cmp_lvl[0];
          res_dir = (dir_ovr_en & dir_ovr_val) | (~dir_ovr_en & ddr);
          res_val = (drv_ovr_en & drv_ovr_val) | (~drv_ovr_en & latch);
          check("R1 R2 resolved direction", res_dir[5:1], exp_dir[5:1]);
          check("R4 R5 R6 resolved value", res_val[5:1] & exp_dir[5:1], exp_val[5:1] & exp_dir[5:1]);
          check("R6 pin1 no dir ovr", dir_ovr_en[1], 1'b0);
        end
      end
    end
  endtask

  task automatic t_mosi_priority();
    idle(); spi_en = 1; spi_master = 1; cmp_en = 3'b100; cmp_lvl = 3'b100; mosi_out = 0; #1;
    check("R5 serial data over compare", {drv_ovr_en[3], drv_ovr_val[3]}, 2'b10);
    spi_master = 0; #1;
    check("R5 compare when slave", {drv_ovr_en[3], drv_ovr_val[3]}, 2'b11);
    spi_en = 0; cmp_en = 3'b000; #1;
    check("R5 no override when idle", drv_ovr_en[3], 1'b0);
  endtask

  task automatic t_pullup();
    idle(); latch = 8'h3C; spi_en = 1; #1;
    check("R3 slave pullup en", pu_ovr_en, 8'h2C);
    check("R3 slave pullup val", pu_ovr_val & 8'h2C, 8'h2C);
    pull_dis = 1; #1;
    check("R3 pullup disabled", pu_ovr_val, 8'h00);
    pull_dis = 0; spi_master = 1; latch = 8'h10; #1;
    check("R3 master pullup", {pu_ovr_en, pu_ovr_val}, 16'h1010);
    spi_en = 0; #1;
    check("R3 idle no pullup ovr", pu_ovr_en, 8'h00);
  endtask

  task automatic t_din();
    idle(); chg_mask = 8'hA5; chg_grp_en = 1; #1;
    check("R7 din en masked", din_ovr_en, 8'hA5);
    check("R7 din val", din_ovr_val, 8'hFF);
    chg_grp_en = 0; #1;
    check("R7 group off", din_ovr_en, 8'h00);
  endtask

  task automatic t_xtal();
    logic f;
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 2; a++) begin
        idle(); clk_src = s[1:0]; async_tmr = a[0]; latch = 8'hC0; #1;
        f = (s == 1 && a == 1) || (s == 2);
        check("R8 xtal pullup en", pu_ovr_en[7:6], {f, f});
        check("R8 xtal dir en", dir_ovr_en[7:6], {f, f});
        check("R8 xtal values off", {pu_ovr_val[7:6], dir_ovr_val[7:6]}, 4'b0000);
        check("R8 xtal no drive", drv_ovr_en[7:6], 2'b00);
      end
    end
  endtask

  task automatic t_clkdiv();
    idle(); clkdiv_en = 1; clkdiv = 1; #1;
    check("R9 clkdiv high", {dir_ovr_en[0], dir_ovr_val[0], drv_ovr_en[0], drv_ovr_val[0]}, 4'b1111);
    clkdiv = 0; #1;
    check("R9 clkdiv low", {dir_ovr_en[0], dir_ovr_val[0], drv_ovr_en[0], drv_ovr_val[0]}, 4'b1110);
    clkdiv_en = 0; clkdiv = 1; latch = 8'h01; #1;
    check("R9 off no override", {pu_ovr_en[0], dir_ovr_en[0], drv_ovr_en[0]}, 3'b000);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_mosi_priority();
    t_pullup();
    t_din();
    t_xtal();
    t_clkdiv();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule